// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a byte-wide serial EEPROM. It watches the two bus wires (clock and data) with the system clock and cleans them up. It finds the bus START and STOP conditions, shifts in the control byte, the word address and the write data, and answers with acknowledge bits. Read data goes out through an open-drain enable, where a 1 pulls the data line low. The engine owns the internal address pointer. Write bytes go out to a separate page buffer as address/data strobes, followed by a commit strobe when the transfer closes. Reads use a synchronous array port whose data arrives one clock after the request.

The device is addressed by a control byte: a fixed 4-bit family code, then three select bits, then the direction bit. The parameter `PAGE_BITS` (0 to 3) builds the larger-array variants. In those variants the lowest select bits of a write control byte stop being compared with the straps and become the high-order bits of the address pointer. While the page buffer signals a write cycle in progress, the engine refuses its control byte, so a master can poll for completion.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o`=0), no strobe is active, and the address pointer is 0.
- R2: A START (data falls while clock is high) in any state restarts control byte reception. A STOP (data rises while clock is high) returns the engine to idle and releases the data line.
- R3: A control byte, MSB first, is acknowledged on the ninth clock only if bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]` (with the default `PAGE_BITS`=0). Otherwise it gets no acknowledge, and the engine ignores the bus until the next START. Bit 0 is 1 for read and 0 for write.
- R4: In a write, the byte after the control byte loads the pointer. Each later byte is acknowledged and presented once on `wb_valid_o` with `wb_addr_o` equal to the pointer, after which the pointer advances by one.
- R5: `wb_commit_o` pulses once on the STOP that ends a write in which at least one data byte arrived. A write carrying only a word address produces no commit.
- R6: While `wb_busy_i` is 1, no control byte is acknowledged. Once it drops, the same byte is acknowledged again.
- R7: A read with no preceding address returns the byte at the last accessed address plus one.
- R8: A write that carries only the word address, followed by a repeated START and a read control byte, reads from that word address.
- R9: In a read, a master acknowledge moves to the next address, wrapping from 255 to 0. A master non-acknowledge releases the data line and leaves the engine idle until the next START.
- R10: Read data is sent MSB first, and the open-drain enable changes only in the cycle after a filtered clock falling edge, or after a START or STOP.
- R11: After an interrupted read, nine clocks with the data line released, followed by a START, bring the engine back to normal operation.
- R12: A pulse of a single system clock on either bus line is rejected by the line filter: it neither counts as a clock bit nor forms a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device select straps |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wb_valid_o | output | 1 | Write byte strobe to the page buffer |
| wb_addr_o | output | 8+PAGE_BITS | Address of the write byte |
| wb_data_o | output | 8 | Write byte |
| wb_commit_o | output | 1 | Start internal write cycle |
| wb_busy_i | input | 1 | Internal write cycle in progress |
| rd_en_o | output | 1 | Array read request |
| rd_addr_o | output | 8+PAGE_BITS | Array read address |
| rd_data_i | input | 8 | Array read data, one clock after the request |

## Verification
The bench reads the whole array in one sequential transaction and lets the pointer wrap past 255. A pointer that saturated or skipped an address on the master acknowledge would return the wrong bytes there, or misplace the following current-address read. It sweeps all eight select codes and polls while the buffer is busy. A comparator that ignored the straps, or ignored busy, would answer polls it must refuse. A dummy write must leave the commit count unchanged. An interrupted read must still let the bus recover with nine clocks and a START. A one-cycle spike on each line must leave the written byte intact; a filter that let it through would shift an extra bit in or see a false STOP.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_RDATA} eep_state_t;

  localparam logic [3:0] FAMILY_CODE = 4'b1010;

  // select bits that are compared against the straps for a given page width
  function automatic logic [2:0] sel_mask(input int page_bits);
    return 3'b111 << page_bits;
  endfunction

  function automatic logic ctrl_hit(input logic [7:0] cb, input logic [2:0] strap,
                                    input logic [2:0] mask);
    return (cb[7:4] == FAMILY_CODE) && (((cb[3:1] ^ strap) & mask) == 3'b000);
  endfunction

  // majority vote over a filter window
  function automatic logic vote(input int ones, input int taps);
    return ones > (taps / 2);
  endfunction
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic q_o,
  output logic qd_o
);
  import eep_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      q_o    <= 1'b1;
      qd_o   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      q_o    <= vote($countones(hist_q), FILT_TAPS);
      qd_o   <= q_o;
    end
  end
endmodule

// File: rtl/eep_bus_events.sv
module eep_bus_events (
  input  logic scl_q,
  input  logic scl_qd,
  input  logic sda_q,
  input  logic sda_qd,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  always_comb begin
    scl_rise = scl_q & ~scl_qd;
    scl_fall = ~scl_q & scl_qd;
    start_ev = scl_q & scl_qd & sda_qd & ~sda_q;
    stop_ev  = scl_q & scl_qd & ~sda_qd & sda_q;
  end
endmodule

// File: rtl/eep_ctl.sv
module eep_ctl #(
  parameter int PAGE_BITS = 0,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_f,
  input  logic [2:0]    strap,
  input  logic          wb_busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [7:0]    wb_data,
  output logic          wb_commit,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);
  import eep_pkg::*;

  localparam logic [2:0] MASK = sel_mask(PAGE_BITS);

  eep_state_t    state, nxt;
  logic [3:0]    cnt;
  logic          in_ack, wr_pend, m_ack, load_q;
  logic [7:0]    rx, tx;
  logic [AW-1:0] ptr, load_val;

  // named internal events
  wire byte_done   = scl_fall && !in_ack && (cnt == 4'd8);
  wire ack_end     = scl_fall && in_ack;
  wire ctrl_ok     = ctrl_hit(rx, strap, MASK) && !wb_busy;
  wire ctrl_wr_acc = byte_done && (state == ST_CTRL) && ctrl_ok && !rx[0];

  generate
    if (PAGE_BITS == 0) begin : g_flat
      assign load_val = rx;
    end else begin : g_paged
      logic [PAGE_BITS-1:0] page_lat;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           page_lat <= '0;
        else if (ctrl_wr_acc) page_lat <= rx[PAGE_BITS:1];
      end
      assign load_val = {page_lat, rx};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  nxt <= ST_IDLE;  cnt <= '0;
      in_ack <= 1'b0;    wr_pend <= 1'b0; m_ack <= 1'b0; load_q <= 1'b0;
      rx <= '0;          tx <= '0;        ptr <= '0;
      sda_oe <= 1'b0;    wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
      wb_commit <= 1'b0; rd_en <= 1'b0;   rd_addr <= '0;
    end else begin
      wb_valid  <= 1'b0;
      wb_commit <= 1'b0;
      rd_en     <= 1'b0;
      load_q    <= rd_en;
      if (load_q) tx <= rd_data;

      if (start_ev) begin
        state   <= ST_CTRL;
        cnt     <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        in_ack    <= 1'b0;
        sda_oe    <= 1'b0;
        wb_commit <= wr_pend;
        wr_pend   <= 1'b0;
      end else begin
        case (state)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && !in_ack && cnt != 4'd8) begin
              rx  <= {rx[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end
            if (ack_end) begin
              in_ack <= 1'b0;
              cnt    <= '0;
              state  <= nxt;
              sda_oe <= (nxt == ST_RDATA) ? ~tx[7] : 1'b0;
            end else if (byte_done) begin
              case (state)
                ST_CTRL: begin
                  if (ctrl_ok) begin
                    sda_oe <= 1'b1;
                    in_ack <= 1'b1;
                    nxt    <= ctrl_wr_acc ? ST_ADDR : ST_RDATA;
                    if (rx[0]) begin
                      rd_en   <= 1'b1;
                      rd_addr <= ptr;
                      ptr     <= ptr + 1'b1;
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_ADDR: begin
                  ptr    <= load_val;
                  sda_oe <= 1'b1;
                  in_ack <= 1'b1;
                  nxt    <= ST_WDATA;
                end
                default: begin
                  wb_valid <= 1'b1;
                  wb_addr  <= ptr;
                  wb_data  <= rx;
                  ptr      <= ptr + 1'b1;
                  wr_pend  <= 1'b1;
                  sda_oe   <= 1'b1;
                  in_ack   <= 1'b1;
                  nxt      <= ST_WDATA;
                end
              endcase
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              if (in_ack) begin
                m_ack <= ~sda_f;
                if (!sda_f) begin
                  rd_en   <= 1'b1;
                  rd_addr <= ptr;
                  ptr     <= ptr + 1'b1;
                end
              end else begin
                cnt <= cnt + 4'd1;
              end
            end else if (scl_fall) begin
              if (in_ack) begin
                in_ack <= 1'b0;
                cnt    <= '0;
                if (m_ack) sda_oe <= ~tx[7];
                else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end else if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                in_ack <= 1'b1;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));
  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_CTRL) && !sda_oe);
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE) && !sda_oe);
  // R5
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_commit |-> $past(stop_ev));
  // R4
  wb_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(scl_fall));
  // R6
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_CTRL && wb_busy) |=> !sda_oe && state == ST_IDLE);
  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && state == ST_RDATA && !m_ack) |=> !sda_oe && state == ST_IDLE);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter int PAGE_BITS   = 0,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [2:0]           strap_i,
  output logic                 sda_oe_o,
  output logic                 wb_valid_o,
  output logic [7+PAGE_BITS:0] wb_addr_o,
  output logic [7:0]           wb_data_o,
  output logic                 wb_commit_o,
  input  logic                 wb_busy_i,
  output logic                 rd_en_o,
  output logic [7+PAGE_BITS:0] rd_addr_o,
  input  logic [7:0]           rd_data_i
);
  localparam int AW = 8 + PAGE_BITS;

  logic [1:0] raw, fq, fqd;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw = {sda_i, scl_i};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_line
      eep_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(raw[i]), .q_o(fq[i]), .qd_o(fqd[i]));
    end
  endgenerate

  eep_bus_events u_ev (
    .scl_q(fq[0]), .scl_qd(fqd[0]), .sda_q(fq[1]), .sda_qd(fqd[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  eep_ctl #(.PAGE_BITS(PAGE_BITS), .AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_f(fq[1]), .strap(strap_i),
    .wb_busy(wb_busy_i), .rd_data(rd_data_i), .sda_oe(sda_oe_o),
    .wb_valid(wb_valid_o), .wb_addr(wb_addr_o), .wb_data(wb_data_o),
    .wb_commit(wb_commit_o), .rd_en(rd_en_o), .rd_addr(rd_addr_o));
endmodule

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int BUSY_CYC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wb_valid, wb_commit, wb_busy = 1'b0, rd_en;
  logic [7:0] wb_addr, rd_addr, wb_data, rd_data = 8'h00;
  logic sda_bus;
  int total = 0, bad = 0, commits = 0, busy_cnt = 0;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] expv [256];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eep_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_oe_o(sda_oe), .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .wb_commit_o(wb_commit), .wb_busy_i(wb_busy), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data));

  // array and page buffer model
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wb_valid) mem[wb_addr] <= wb_data;
    if (wb_commit) begin
      commits  <= commits + 1;
      wb_busy  <= 1'b1;
      busy_cnt <= BUSY_CYC;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) wb_busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic bit_out(input bit b, input bit glitch, output bit line);
    sda_m = b;
    if (glitch) begin
      w(3); scl_m = 1; w(1); scl_m = 0; w(Q - 4);
      scl_m = 1; w(3); sda_m = ~b; w(1); sda_m = b; w(Q - 4);
    end else begin
      w(Q); scl_m = 1; w(Q);
    end
    line = sda_bus;
    w(Q); scl_m = 0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int g, output bit ack);
    bit l;
    for (int i = 7; i >= 0; i--) bit_out(b[i], (i == g), l);
    bit_out(1'b1, 1'b0, l);
    ack = ~l;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit l;
    for (int i = 0; i < 8; i++) begin
      bit_out(1'b1, 1'b0, l);
      d = {d[6:0], l};
    end
    bit_out(~mack, 1'b0, l);
  endtask

  task automatic ctrl(input bit rd, output bit ack);
    bus_start();
    send_byte({4'b1010, STRAP, rd}, -1, ack);
  endtask

  task automatic wait_ready();
    w(2);
    while (wb_busy) w(1);
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output bit ok);
    bit k1, k2, k3;
    ctrl(1'b0, k1); send_byte(a, -1, k2); ctrl(1'b1, k3);
    recv_byte(1'b0, d); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic cur_read(output logic [7:0] d, output bit ok);
    ctrl(1'b1, ok); recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a1, a2, a3, ok;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'((i * 37 + 11) & 255);
      expv[i] = mem[i];
    end
    w(5); rst_n = 1; w(5);
    // R1 reset state
    chk(sda_oe == 0 && wb_valid == 0 && rd_en == 0 && wb_commit == 0, "R1 reset", int'(sda_oe), 0);

    // R1 pointer starts at 0: current read returns address 0
    cur_read(d, ok);
    chk(ok && d == expv[0], "R1 pointer reset", int'(d), int'(expv[0]));

    // R3 select code sweep: only the strapped code is acknowledged
    for (int s = 0; s < 8; s++) begin
      bus_start(); send_byte({4'b1010, 3'(s), 1'b0}, -1, a1); bus_stop();
      chk(a1 == (3'(s) == STRAP), "R3 strap sweep", int'(a1), int'(3'(s) == STRAP));
    end
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, -1, a1); send_byte(8'h00, -1, a2); bus_stop();
    chk(!a1 && !a2, "R3 wrong family ignored", int'(a1 | a2), 0);

    // R4 R5 byte write
    c0 = commits;
    ctrl(1'b0, a1); send_byte(8'h40, -1, a2); send_byte(8'hA5, -1, a3); bus_stop();
    expv[8'h40] = 8'hA5;
    w(2);
    chk(a1 && a2 && a3, "R4 write acks", int'({a1, a2, a3}), 7);
    chk(mem[8'h40] == 8'hA5, "R4 byte stored", int'(mem[8'h40]), 8'hA5);
    chk(commits == c0 + 1, "R5 commit after stop", commits, c0 + 1);

    // R6 polling while busy
    ctrl(1'b0, a1); bus_stop();
    chk(!a1, "R6 refused while busy", int'(a1), 0);
    wait_ready();
    ctrl(1'b0, a1); bus_stop();
    chk(a1, "R6 accepted after busy", int'(a1), 1);

    // R8 random read, R5 no commit for dummy write
    c0 = commits;
    rand_read(8'h40, d, ok);
    chk(ok && d == 8'hA5, "R8 random read", int'(d), 8'hA5);
    chk(commits == c0, "R5 no commit for address-only write", commits, c0);

    // R7 current address read
    cur_read(d, ok);
    chk(ok && d == expv[8'h41], "R7 current read", int'(d), int'(expv[8'h41]));

    // R4 page write, then R7 pointer after write
    ctrl(1'b0, a1); send_byte(8'h10, -1, a2);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'hC0 + i), -1, a3);
      expv[8'h10 + i] = 8'(8'hC0 + i);
      chk(a3, "R4 page byte ack", int'(a3), 1);
    end
    bus_stop(); wait_ready();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h10 + i] == expv[8'h10 + i], "R4 page stored", int'(mem[8'h10 + i]), int'(expv[8'h10 + i]));
    cur_read(d, ok);
    chk(ok && d == expv[8'h14], "R7 pointer after write", int'(d), int'(expv[8'h14]));

    // R9 sequential read across the top of the array
    ctrl(1'b0, a1); send_byte(8'hFE, -1, a2); ctrl(1'b1, a3);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk(d == expv[8'(8'hFE + i)], "R9 wrap read", int'(d), int'(expv[8'(8'hFE + i)]));
    end
    bus_stop();
    chk(sda_oe == 0, "R9 released after nack", int'(sda_oe), 0);
    cur_read(d, ok);
    chk(ok && d == expv[2], "R9 pointer after wrap", int'(d), int'(expv[2]));

    // R11 bus recovery after an interrupted read
    ctrl(1'b0, a1); send_byte(8'h07, -1, a2); ctrl(1'b1, a3);
    for (int i = 0; i < 3; i++) bit_out(1'b1, 1'b0, ok);
    for (int i = 0; i < 9; i++) bit_out(1'b1, 1'b0, ok);
    rand_read(8'h41, d, ok);
    chk(ok && d == expv[8'h41], "R11 recovery", int'(d), int'(expv[8'h41]));

    // R12 glitches on both lines during a data byte
    ctrl(1'b0, a1); send_byte(8'h55, -1, a2); send_byte(8'h3C, 4, a3); bus_stop();
    expv[8'h55] = 8'h3C;
    wait_ready();
    chk(a1 && a2 && a3 && mem[8'h55] == 8'h3C, "R12 glitch rejected", int'(mem[8'h55]), 8'h3C);

    // R2 START mid-byte restarts control reception
    ctrl(1'b0, a1); for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0, ok);
    rand_read(8'h55, d, ok);
    chk(ok && d == 8'h3C, "R2 restart mid byte", int'(d), 8'h3C);

    // R9 R10 whole array in one sequential read, MSB first
    ctrl(1'b0, a1); send_byte(8'h00, -1, a2); ctrl(1'b1, a3);
    for (int i = 0; i < 256; i++) begin
      recv_byte(i != 255, d);
      chk(d == expv[i], "R10 sequential data", int'(d), int'(expv[i]));
    end
    bus_stop();
    cur_read(d, ok);
    chk(ok && d == expv[0], "R9 full wrap", int'(d), int'(expv[0]));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule